// File: doc/BRIEF.md
# Programmable Per-Line Edge Event Bank

This block watches a wide bus of single-bit signals and raises a one-cycle event for every line on which the chosen kind of transition occurred. Software picks the transition kind for each line separately: a low-to-high change, a high-to-low change, or any change. It can also silence individual lines with a mask. All settings live in a small bank of 32-bit registers on a simple memory-mapped read/write port, and every register can be read back.

Each clock cycle the block compares the current input sample with the sample it registered on the previous cycle. It applies each line's transition code, its mask and a global enable bit. It registers the result as a per-line event vector and as a single flag that is high when any line fired. Configuration is expected to be loaded before the enable bit is set. While the block is disabled it keeps tracking the previous sample, so turning it on never reports stale transitions.

Top module: `edgewatch_bank`

## Requirements
- R1: The block monitors 256 lines; `evt_out[i]` reports only on `sig_in[i]`, for every i from 0 to 255.
- R2: Transition codes per line: 2'b00 fires when the line goes 0→1, 2'b01 fires when it goes 1→0, 2'b10 fires on either change.
- R3: Code 2'b11 never produces an event on its line.
- R4: Control word n (n = 0..15) sits at byte offset 0x808 + 4n; line r takes its code from word r/16, bits [2(r mod 16)+1 : 2(r mod 16)].
- R5: Mask word n (n = 0..7) sits at byte offset 0x848 + 4n; line r uses bit r mod 32 of word r/32; a 1 suppresses that line's event and a 0 lets it through.
- R6: Bit 0 of the enable word at offset 0x800 gates detection. While it is 0, `evt_out` and `evt_any` stay low, but the previous sample is still updated. Setting it while the inputs hold steady therefore produces no event.
- R7: An input change sampled at clock edge k appears on `evt_out` after edge k and lasts exactly one cycle if the input then holds.
- R8: `evt_any` is high in exactly the cycles in which at least one bit of `evt_out` is high.
- R9: A read (`rd_en` high at an edge) returns the addressed register on `rdata` after that edge; while `rd_en` is low, `rdata` is 0.
- R10: Offsets that are not the enable, control or mask words, including any with address bits [1:0] not zero, read as 0, and writes to them change nothing.
- R11: Synchronous reset clears all registers, the previous sample, `evt_out`, `evt_any` and `rdata` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte offset of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| sig_in | input | 256 | Monitored lines, already synchronous to `clk` |
| evt_out | output | 256 | Registered per-line event pulses |
| evt_any | output | 1 | Registered OR of all event pulses |

## Verification
The hardest situation to reach from the ports is the interplay of each line's code with its mask and with the packing: a fault that touches one field position or one word boundary shows only when that exact line both moves in the right direction and is unmasked. The bench therefore loads two complete configurations in which the code cycles through all four values with a line-dependent shift and the mask falls on every seventh line at a shifting phase. It then drives all-rise, all-fall and several arithmetic mixed patterns and compares all 256 lines against a model in every case. The enable-off tracking case is reached by toggling inputs while disabled, then enabling with the inputs held and looking for a stray pulse.

// File: rtl/edgewatch_pkg.sv
package edgewatch_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_RSVD = 2'b11
  } edge_sel_e;

  // Transition test for one line given its current and previous sample
  function automatic logic edge_hit(input logic cur, input logic prev,
                                    input logic [1:0] sel);
    case (sel)
      EDGE_RISE: return cur & ~prev;
      EDGE_FALL: return ~cur & prev;
      EDGE_BOTH: return cur ^ prev;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/edgewatch_regs.sv
module edgewatch_regs #(
  parameter int NUM_LINES  = 256,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 12,
  parameter int ENA_OFFSET = 'h800,
  parameter int CTRL_BASE  = 'h808,
  parameter int MASK_BASE  = 'h848
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W-1:0]      rdata,
  output logic                   det_en,
  output logic [2*NUM_LINES-1:0] ctrl_flat,
  output logic [NUM_LINES-1:0]   mask_flat
);

  localparam int CODES_PER_WORD = DATA_W / 2;
  localparam int CTRL_WORDS     = NUM_LINES / CODES_PER_WORD;
  localparam int MASK_WORDS     = NUM_LINES / DATA_W;
  localparam int CIDX_W         = (CTRL_WORDS > 1) ? $clog2(CTRL_WORDS) : 1;
  localparam int MIDX_W         = (MASK_WORDS > 1) ? $clog2(MASK_WORDS) : 1;
  localparam logic [ADDR_W-1:0] ENA_A   = ADDR_W'(ENA_OFFSET);
  localparam logic [ADDR_W-1:0] CTRL_LO = ADDR_W'(CTRL_BASE);
  localparam logic [ADDR_W-1:0] CTRL_HI = ADDR_W'(CTRL_BASE + 4 * CTRL_WORDS);
  localparam logic [ADDR_W-1:0] MASK_LO = ADDR_W'(MASK_BASE);
  localparam logic [ADDR_W-1:0] MASK_HI = ADDR_W'(MASK_BASE + 4 * MASK_WORDS);

  logic [DATA_W-1:0] ctrl_q [CTRL_WORDS];
  logic [DATA_W-1:0] mask_q [MASK_WORDS];
  logic              ena_q;

  logic              aligned, ena_hit, ctrl_hit, mask_hit;
  logic [ADDR_W-1:0] ctrl_off, mask_off;
  logic [CIDX_W-1:0] ctrl_idx;
  logic [MIDX_W-1:0] mask_idx;
  logic [DATA_W-1:0] rd_val;

  // Address decode: word aligned, range compare per register group
  always_comb begin
    aligned  = (addr[1:0] == 2'b00);
    ena_hit  = aligned && (addr == ENA_A);
    ctrl_hit = aligned && (addr >= CTRL_LO) && (addr < CTRL_HI);
    mask_hit = aligned && (addr >= MASK_LO) && (addr < MASK_HI);
    ctrl_off = addr - CTRL_LO;
    mask_off = addr - MASK_LO;
    ctrl_idx = CIDX_W'(ctrl_off >> 2);
    mask_idx = MIDX_W'(mask_off >> 2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ena_q <= 1'b0;
      for (int w = 0; w < CTRL_WORDS; w++) ctrl_q[w] <= '0;
      for (int w = 0; w < MASK_WORDS; w++) mask_q[w] <= '0;
    end else if (wr_en) begin
      if (ena_hit)  ena_q            <= wdata[0];
      if (ctrl_hit) ctrl_q[ctrl_idx] <= wdata;
      if (mask_hit) mask_q[mask_idx] <= wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    if (ena_hit)       rd_val = {{(DATA_W-1){1'b0}}, ena_q};
    else if (ctrl_hit) rd_val = ctrl_q[ctrl_idx];
    else if (mask_hit) rd_val = mask_q[mask_idx];
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_val;
    else            rdata <= '0;
  end

  generate
    for (genvar w = 0; w < CTRL_WORDS; w++) begin : g_ctrl_flat
      assign ctrl_flat[w*DATA_W +: DATA_W] = ctrl_q[w];
    end
    for (genvar w = 0; w < MASK_WORDS; w++) begin : g_mask_flat
      assign mask_flat[w*DATA_W +: DATA_W] = mask_q[w];
    end
  endgenerate

  assign det_en = ena_q;

endmodule

// File: rtl/edgewatch_lane.sv
module edgewatch_lane
  import edgewatch_pkg::*;
(
  input  logic       cur,
  input  logic       prev,
  input  logic [1:0] sel,
  input  logic       masked,
  input  logic       enable,
  output logic       hit
);

  always_comb begin
    hit = enable && !masked && edge_hit(cur, prev, sel);
  end

endmodule

// File: rtl/edgewatch_bank.sv
module edgewatch_bank #(
  parameter int NUM_LINES  = 256,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 12,
  parameter int ENA_OFFSET = 'h800,
  parameter int CTRL_BASE  = 'h808,
  parameter int MASK_BASE  = 'h848
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  input  logic [NUM_LINES-1:0] sig_in,
  output logic [NUM_LINES-1:0] evt_out,
  output logic                 evt_any
);

  logic                   det_en;
  logic [2*NUM_LINES-1:0] ctrl_flat;
  logic [NUM_LINES-1:0]   mask_flat;
  logic [NUM_LINES-1:0]   prev_q;
  logic [NUM_LINES-1:0]   hit_vec;

  edgewatch_regs #(
    .NUM_LINES (NUM_LINES),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .ENA_OFFSET(ENA_OFFSET),
    .CTRL_BASE (CTRL_BASE),
    .MASK_BASE (MASK_BASE)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .det_en   (det_en),
    .ctrl_flat(ctrl_flat),
    .mask_flat(mask_flat)
  );

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_lane
      edgewatch_lane u_lane (
        .cur   (sig_in[i]),
        .prev  (prev_q[i]),
        .sel   (ctrl_flat[2*i +: 2]),
        .masked(mask_flat[i]),
        .enable(det_en),
        .hit   (hit_vec[i])
      );
    end
  endgenerate

  // Previous sample is tracked regardless of the enable bit
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      evt_out <= '0;
      evt_any <= 1'b0;
    end else begin
      prev_q  <= sig_in;
      evt_out <= hit_vec;
      evt_any <= |hit_vec;
    end
  end

endmodule

// File: rtl/edgewatch_chk.sv
module edgewatch_chk #(
  parameter int NUM_LINES  = 256,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 12,
  parameter int ENA_OFFSET = 'h800,
  parameter int CTRL_BASE  = 'h808,
  parameter int MASK_BASE  = 'h848
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 rd_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    rdata,
  input logic [NUM_LINES-1:0] sig_in,
  input logic [NUM_LINES-1:0] evt_out,
  input logic                 evt_any,
  input logic [NUM_LINES-1:0] mask_flat,
  input logic                 det_en
);

  localparam int CTRL_WORDS = NUM_LINES / (DATA_W / 2);
  localparam int MASK_WORDS = NUM_LINES / DATA_W;
  localparam logic [ADDR_W-1:0] ENA_A   = ADDR_W'(ENA_OFFSET);
  localparam logic [ADDR_W-1:0] CTRL_LO = ADDR_W'(CTRL_BASE);
  localparam logic [ADDR_W-1:0] CTRL_HI = ADDR_W'(CTRL_BASE + 4 * CTRL_WORDS);
  localparam logic [ADDR_W-1:0] MASK_LO = ADDR_W'(MASK_BASE);
  localparam logic [ADDR_W-1:0] MASK_HI = ADDR_W'(MASK_BASE + 4 * MASK_WORDS);

  logic armed;
  logic mapped;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  always_comb begin
    mapped = (addr[1:0] == 2'b00) &&
             ((addr == ENA_A) ||
              ((addr >= CTRL_LO) && (addr < CTRL_HI)) ||
              ((addr >= MASK_LO) && (addr < MASK_HI)));
  end

  AST_MASKED_LINES_QUIET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((evt_out & $past(mask_flat)) == '0)); // R5

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !det_en |=> (evt_out == '0 && !evt_any)); // R6

  AST_HELD_INPUT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (armed && $stable(sig_in)) |=> (evt_out == '0)); // R7

  AST_ANY_MATCHES_VECTOR: assert property (@(posedge clk) disable iff (rst)
    evt_any == (|evt_out)); // R8

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0)); // R9

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !mapped) |=> (rdata == '0)); // R10

endmodule

bind edgewatch_bank edgewatch_chk #(
  .NUM_LINES (NUM_LINES),
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .ENA_OFFSET(ENA_OFFSET),
  .CTRL_BASE (CTRL_BASE),
  .MASK_BASE (MASK_BASE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_en    (rd_en),
  .addr     (addr),
  .rdata    (rdata),
  .sig_in   (sig_in),
  .evt_out  (evt_out),
  .evt_any  (evt_any),
  .mask_flat(mask_flat),
  .det_en   (det_en)
);

// File: tb/edgewatch_bank_tb.sv
`timescale 1ns/1ps
module edgewatch_bank_tb;

  localparam int N = 256;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  sig_in = '0;
  logic [N-1:0]  evt_out;
  logic          evt_any;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [1:0]   m_code [N];
  logic         m_mask [N];
  logic         m_en;
  logic [N-1:0] m_prev;

  always #5 clk = ~clk;

  edgewatch_bank u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sig_in(sig_in), .evt_out(evt_out),
    .evt_any(evt_any)
  );

  task automatic check_vec(input string req, input logic [N-1:0] act,
                           input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check32(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [11:0] a, input logic [31:0] exp,
                        input string req);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check32(req, rdata, exp);
  endtask

  function automatic logic model_hit(input int i, input logic cur);
    logic p;
    p = m_prev[i];
    if (!m_en || m_mask[i]) return 1'b0;
    case (m_code[i])
      2'b00:   return cur & ~p;
      2'b01:   return ~cur & p;
      2'b10:   return cur ^ p;
      default: return 1'b0;
    endcase
  endfunction

  // Drive a new input vector, check the pulse, then check it is gone
  task automatic step(input logic [N-1:0] nv, input string req);
    logic [N-1:0] exp;
    for (int i = 0; i < N; i++) exp[i] = model_hit(i, nv[i]);
    @(negedge clk);
    sig_in = nv;
    @(negedge clk);
    check_vec(req, evt_out, exp);                       // R1 R2 R3 R5
    check32("R8 any-event", {31'b0, evt_any}, {31'b0, |exp});
    m_prev = nv;
    @(negedge clk);
    check_vec("R7 single-cycle pulse", evt_out, '0);
  endtask

  // Load a full configuration and read all of it back
  task automatic load_config(input int sh);
    logic [31:0] w;
    for (int i = 0; i < N; i++) begin
      m_code[i] = 2'((i + sh) % 4);
      m_mask[i] = ((i % 7) == sh);
    end
    for (int n = 0; n < 16; n++) begin
      w = '0;
      for (int j = 0; j < 16; j++) w[2*j +: 2] = m_code[16*n + j];
      reg_wr(12'(32'h808 + 4*n), w);
    end
    for (int n = 0; n < 8; n++) begin
      w = '0;
      for (int j = 0; j < 32; j++) w[j] = m_mask[32*n + j];
      reg_wr(12'(32'h848 + 4*n), w);
    end
    for (int n = 0; n < 16; n++) begin
      w = '0;
      for (int j = 0; j < 16; j++) w[2*j +: 2] = m_code[16*n + j];
      reg_rd(12'(32'h808 + 4*n), w, "R4 R9 control readback");
    end
    for (int n = 0; n < 8; n++) begin
      w = '0;
      for (int j = 0; j < 32; j++) w[j] = m_mask[32*n + j];
      reg_rd(12'(32'h848 + 4*n), w, "R5 R9 mask readback");
    end
  endtask

  function automatic logic [N-1:0] pat(input int s);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = (((i * s) + s) % 5) < 2;
    return v;
  endfunction

  task automatic sweep(input int sh);
    load_config(sh);
    step({N{1'b1}}, "R2 all rising");
    step('0,        "R2 all falling");
    step(pat(3),    "R2 R3 mixed A");
    step(pat(7),    "R2 R3 mixed B");
    step(~pat(3),   "R2 R3 mixed C");
    step({1'b1, {(N-1){1'b0}}}, "R1 top line alone");
    step({N{1'b0}} | 1, "R1 line 0 with top falling");
    step('0, "R1 clear");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    m_en = 1'b0;
    m_prev = '0;
    for (int i = 0; i < N; i++) begin m_code[i] = 2'b00; m_mask[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    check_vec("R11 reset evt_out", evt_out, '0);
    check32("R11 reset evt_any", {31'b0, evt_any}, 32'h0);
    check32("R11 reset rdata", rdata, 32'h0);
    reg_rd(12'h800, 32'h0, "R11 reset enable");
    reg_rd(12'h808, 32'h0, "R11 reset control");
    reg_rd(12'h864, 32'h0, "R11 reset mask");

    // R6 disabled: toggles give no events but prev keeps tracking
    step({N{1'b1}}, "R6 disabled rising");
    step(pat(3), "R6 disabled mixed");
    reg_wr(12'h800, 32'h1);
    m_en = 1'b1;
    reg_rd(12'h800, 32'h1, "R6 R9 enable readback");
    @(negedge clk);
    check_vec("R6 no stale event after enable", evt_out, '0);

    sweep(0);
    sweep(1);
    sweep(3);

    // R10 unmapped reads
    reg_rd(12'h804, 32'h0, "R10 gap read");
    reg_rd(12'h868, 32'h0, "R10 past mask read");
    reg_rd(12'h80A, 32'h0, "R10 misaligned read");
    reg_rd(12'h000, 32'h0, "R10 low offset read");
    // R10 unmapped writes change nothing
    reg_wr(12'h868, 32'hFFFF_FFFF);
    reg_wr(12'h84A, 32'hFFFF_FFFF);
    reg_wr(12'h804, 32'hFFFF_FFFF);
    reg_wr(12'h802, 32'h0);
    reg_rd(12'h800, 32'h1, "R10 enable untouched");
    begin
      logic [31:0] w;
      w = '0;
      for (int j = 0; j < 32; j++) w[j] = m_mask[j];
      reg_rd(12'h848, w, "R10 mask word 0 untouched");
      w = '0;
      for (int j = 0; j < 16; j++) w[2*j +: 2] = m_code[240 + j];
      reg_rd(12'h844, w, "R10 control word 15 untouched");
    end
    step(pat(11), "R10 detection unchanged after stray writes");

    // R6 disable again: outputs silent while inputs move
    reg_wr(12'h800, 32'h0);
    m_en = 1'b0;
    step(~pat(11), "R6 disabled after clear");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule